// File: doc/BRIEF.md
# Load Element Width Converter

This stage converts a word returned by memory into the value that is written to a destination vector element. The raw word carries the loaded value in its low bytes. The operation width is the width of the load. The destination element width is set separately and may be narrower or wider than the operation width.

The stage first decides whether to reverse the byte order. It combines the byte-reverse flag from the opcode with the current endian mode, and a reversal covers only the bytes of the operation width. The result then goes through one of two paths. The plain path zero-extends the value or cuts it down to the destination width. The saturating path sign-extends or zero-extends the value and then clamps it to the range of the destination width, either signed or unsigned.

The stage is one registered pipeline step with a valid flag on each side. The element is returned in the low bits of a 64-bit result, and every bit above the destination width is zero.

Top module: `ld_elem_convert`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the following edge sets `out_valid` to 0 and `out_data` to zero.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge. A result accepted at edge k appears on `out_data` after edge k.
- R3: When `in_valid` is low at an edge, `out_data` keeps its previous value.
- R4: Bytes are reversed exactly when `rev_op` equals `le_mode`: (1,1) and (0,0) reverse, (0,1) and (1,0) pass the bytes through unchanged.
- R5: Width codes on `op_ew` and `dst_ew` are 0=8, 1=16, 2=32 and 3=64 bits. Reversal covers only the low op-width bytes, and bits of `in_data` above the operation width have no effect on the result.
- R6: With `sat_en` = 0, the op-width value is zero-extended to the destination width, or cut down to it when the destination is narrower.
- R7: With `sat_en` = 1 and `sat_signed` = 0, the op-width value is zero-extended and clamped to at most 2^w-1, where w is the destination width.
- R8: With `sat_en` = 1 and `sat_signed` = 1, the op-width value is sign-extended and clamped to the range -2^(w-1) to 2^(w-1)-1, then given in w-bit two's complement.
- R9: Every bit of `out_data` at or above the destination width is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 64 | Raw loaded word; the value sits in the low op-width bytes |
| op_ew | input | 2 | Operation width code |
| dst_ew | input | 2 | Destination element width code |
| rev_op | input | 1 | Byte-reverse opcode flag |
| le_mode | input | 1 | Little-endian mode flag |
| sat_en | input | 1 | Selects the saturating path |
| sat_signed | input | 1 | 1 = signed saturation, 0 = unsigned |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Converted element in the low bits, upper bits zero |

## Verification
Each conversion result, and the matching `out_valid`, is due one rising edge after its input is presented. The bench drives inputs on the falling edge and checks the outputs on the next falling edge, which falls after exactly one register stage. A word presented on every cycle is therefore checked against its own vector, with no skew between the two. The hold and reset checks sample over two falling edges, so that a register that updates one cycle late shows up as a mismatch.

// File: rtl/ldconv_pkg.sv
// Package: shared width-code type for the load element converter.
// Assumes a 64-bit datapath with four power-of-two widths from 8 to 64 bits.
package ldconv_pkg;
    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ew_e;
endpackage

// File: rtl/ldconv_byteswap.sv
// Byte reversal over the low 2^code bytes of the word.
// Assumes DATA_W is a multiple of 8 and that NCODE covers 1..DATA_W/8 bytes.
// Bytes above the selected width are passed through and are masked later.
module ldconv_byteswap #(
    parameter int DATA_W = 64,
    parameter int NCODE  = 4,
    parameter int CODE_W = 2
) (
    input  logic [DATA_W-1:0] din,
    input  logic [CODE_W-1:0] code,
    input  logic              swap,
    output logic [DATA_W-1:0] dout
);
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] cand [NCODE];

    // One reversed candidate per width code.
    for (genvar c = 0; c < NCODE; c++) begin : g_w
        localparam int NB = 1 << c;
        for (genvar b = 0; b < NBYTES; b++) begin : g_b
            if (b < NB) begin : g_rev
                assign cand[c][8*b +: 8] = din[8*(NB-1-b) +: 8];
            end else begin : g_keep
                assign cand[c][8*b +: 8] = din[8*b +: 8];
            end
        end
    end

    // Pick the candidate for the operation width, or bypass.
    always_comb begin
        dout = swap ? cand[code] : din;
    end
endmodule

// File: rtl/ldconv_widen.sv
// Extends the op-width value to the full word, by sign or by zero.
// Assumes bits above the op width are junk and must not leak through.
module ldconv_widen #(
    parameter int DATA_W = 64,
    parameter int NCODE  = 4,
    parameter int CODE_W = 2
) (
    input  logic [DATA_W-1:0] din,
    input  logic [CODE_W-1:0] code,
    input  logic              sext,
    output logic [DATA_W-1:0] dout
);
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] ext [NCODE];

    // Extended form for each operation width.
    for (genvar c = 0; c < NCODE; c++) begin : g_w
        localparam int NB = 1 << c;
        if (NB >= NBYTES) begin : g_full
            assign ext[c] = din;
        end else begin : g_part
            assign ext[c] = {{(DATA_W-8*NB){sext & din[8*NB-1]}}, din[8*NB-1:0]};
        end
    end

    // Select by operation width.
    always_comb begin
        dout = ext[code];
    end
endmodule

// File: rtl/ldconv_narrow.sv
// Reduces the full-word value to the destination width: plain mask,
// unsigned clamp or signed clamp. Bits above the destination width leave as zero.
// Assumes the input was sign-extended for signed saturation and zero-extended otherwise.
module ldconv_narrow #(
    parameter int DATA_W = 64,
    parameter int NCODE  = 4,
    parameter int CODE_W = 2
) (
    input  logic [DATA_W-1:0] din,
    input  logic [CODE_W-1:0] code,
    input  logic              sat_en,
    input  logic              sat_signed,
    output logic [DATA_W-1:0] dout
);
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] res [NCODE];

    // Result candidate for each destination width.
    for (genvar c = 0; c < NCODE; c++) begin : g_w
        localparam int NB = 1 << c;
        localparam int W  = 8 * NB;
        logic [DATA_W-1:0] mask, smax, smin;
        logic              fit_u, fit_s;
        if (NB >= NBYTES) begin : g_full
            assign mask  = '1;
            assign fit_u = 1'b1;
            assign fit_s = 1'b1;
        end else begin : g_part
            assign mask  = {{(DATA_W-W){1'b0}}, {W{1'b1}}};
            assign fit_u = ~|din[DATA_W-1:W];
            assign fit_s = (&din[DATA_W-1:W-1]) | ~|din[DATA_W-1:W-1];
        end
        assign smax = mask >> 1;
        assign smin = mask & ~smax;
        always_comb begin
            if (!sat_en)
                res[c] = din & mask;
            else if (!sat_signed)
                res[c] = fit_u ? din : mask;
            else if (fit_s)
                res[c] = din & mask;
            else
                res[c] = din[DATA_W-1] ? smin : smax;
        end
    end

    // Select by destination width.
    always_comb begin
        dout = res[code];
    end
endmodule

// File: rtl/ld_elem_convert.sv
// Top of the load element converter: byte order, widen, narrow, one register.
// Assumes width codes 0..3 map to 8/16/32/64 bits; latency is one cycle.
// The output register holds its value when no valid input arrives.
module ld_elem_convert #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        op_ew,
    input  logic [1:0]        dst_ew,
    input  logic              rev_op,
    input  logic              le_mode,
    input  logic              sat_en,
    input  logic              sat_signed,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    import ldconv_pkg::*;

    localparam int NBYTES = DATA_W / 8;
    localparam int NCODE  = $clog2(NBYTES) + 1;
    localparam int CODE_W = 2;

    ew_e               op_code, dst_code;
    logic              do_swap;
    logic [DATA_W-1:0] swapped, widened, narrowed;

    // Decode the width codes and the merged swap condition.
    always_comb begin
        op_code  = ew_e'(op_ew);
        dst_code = ew_e'(dst_ew);
        do_swap  = ~(rev_op ^ le_mode);
    end

    ldconv_byteswap #(.DATA_W(DATA_W), .NCODE(NCODE), .CODE_W(CODE_W)) u_swap (
        .din  (in_data),
        .code (op_code),
        .swap (do_swap),
        .dout (swapped)
    );

    ldconv_widen #(.DATA_W(DATA_W), .NCODE(NCODE), .CODE_W(CODE_W)) u_widen (
        .din  (swapped),
        .code (op_code),
        .sext (sat_en & sat_signed),
        .dout (widened)
    );

    ldconv_narrow #(.DATA_W(DATA_W), .NCODE(NCODE), .CODE_W(CODE_W)) u_narrow (
        .din        (widened),
        .code       (dst_code),
        .sat_en     (sat_en),
        .sat_signed (sat_signed),
        .dout       (narrowed)
    );

    // Output stage register with synchronous reset and hold on idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= narrowed;
        end
    end
endmodule

// File: rtl/ld_elem_convert_chk.sv
// Checker for the load element converter, bound to the top module.
// Relates the input ports at one edge to the outputs after the next.
module ld_elem_convert_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  op_ew,
    input logic [1:0]  dst_ew,
    input logic        sat_en,
    input logic        sat_signed,
    input logic        out_valid,
    input logic [63:0] out_data
);
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    p_upper8_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_ew == 2'd0) |=> (out_data[63:8] == '0));

    p_upper16_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_ew == 2'd1) |=> (out_data[63:16] == '0));

    p_upper32_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_ew == 2'd2) |=> (out_data[63:32] == '0));

    p_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sat_en && op_ew == 2'd0) |=> (out_data[63:8] == '0));

    p_usat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en && !sat_signed && op_ew == 2'd1) |=> (out_data[63:16] == '0));
endmodule

bind ld_elem_convert ld_elem_convert_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_ew      (op_ew),
    .dst_ew     (dst_ew),
    .sat_en     (sat_en),
    .sat_signed (sat_signed),
    .out_valid  (out_valid),
    .out_data   (out_data)
);

// File: tb/sim_ld_elem_convert.sv
module sim_ld_elem_convert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [1:0]  op_ew = '0;
    logic [1:0]  dst_ew = '0;
    logic        rev_op = 1'b0;
    logic        le_mode = 1'b1;
    logic        sat_en = 1'b0;
    logic        sat_signed = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ld_elem_convert u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .op_ew(op_ew), .dst_ew(dst_ew), .rev_op(rev_op), .le_mode(le_mode),
        .sat_en(sat_en), .sat_signed(sat_signed),
        .out_valid(out_valid), .out_data(out_data)
    );

    // {data, op, dst, rev, le, sat, sgn, expected}
    localparam int NV = 19;
    localparam logic [135:0] VEC [NV] = '{
        {64'hFFFF_FFFF_FFFF_FF85, 2'd0, 2'd3, 4'b0100, 64'h0000_0000_0000_0085}, // R5 R6
        {64'hFFFF_FFFF_FFFF_FF85, 2'd0, 2'd3, 4'b0111, 64'hFFFF_FFFF_FFFF_FF85}, // R8
        {64'h0000_0000_1234_5678, 2'd2, 2'd1, 4'b0100, 64'h0000_0000_0000_5678}, // R6
        {64'hDEAD_BEEF_1234_5678, 2'd2, 2'd3, 4'b1100, 64'h0000_0000_7856_3412}, // R4 R5
        {64'h0000_0000_0000_ABCD, 2'd1, 2'd3, 4'b0000, 64'h0000_0000_0000_CDAB}, // R4
        {64'h0102_0304_0506_0708, 2'd3, 2'd3, 4'b1100, 64'h0807_0605_0403_0201}, // R4
        {64'h0000_0000_0000_1234, 2'd2, 2'd0, 4'b0110, 64'h0000_0000_0000_00FF}, // R7
        {64'h0000_0000_0000_007F, 2'd2, 2'd0, 4'b0110, 64'h0000_0000_0000_007F}, // R7
        {64'h0000_0000_FFFF_FF00, 2'd2, 2'd0, 4'b0111, 64'h0000_0000_0000_0080}, // R8 R9
        {64'h0000_0000_0000_0200, 2'd1, 2'd0, 4'b0111, 64'h0000_0000_0000_007F}, // R8
        {64'h0000_0000_0000_FFF0, 2'd1, 2'd0, 4'b0111, 64'h0000_0000_0000_00F0}, // R8
        {64'h0000_0000_8000_0000, 2'd2, 2'd1, 4'b0111, 64'h0000_0000_0000_8000}, // R8
        {64'h0000_0000_0000_8000, 2'd1, 2'd0, 4'b0110, 64'h0000_0000_0000_00FF}, // R7
        {64'h0000_0000_0000_0080, 2'd0, 2'd2, 4'b0111, 64'h0000_0000_FFFF_FF80}, // R8 R9
        {64'h0000_0000_0000_0080, 2'd0, 2'd2, 4'b0100, 64'h0000_0000_0000_0080}, // R6
        {64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'd2, 4'b0110, 64'h0000_0000_FFFF_FFFF}, // R7
        {64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'd1, 4'b0111, 64'h0000_0000_0000_FFFF}, // R8 R9
        {64'h0000_0000_0000_0080, 2'd1, 2'd0, 4'b1111, 64'h0000_0000_0000_0080}, // R4 R8
        {64'hAAAA_AAAA_AAAA_AA11, 2'd0, 2'd0, 4'b0100, 64'h0000_0000_0000_0011}  // R5 R6
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset data", out_data, 64'd0);
        rst_n = 1'b1;

        // Table walk: drive at one falling edge, check at the next (R2).
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R2 valid", {63'd0, out_valid}, 64'd1);
                check("R4-R9 data", out_data, VEC[i-1][63:0]);
            end
            in_valid   = 1'b1;
            in_data    = VEC[i][135:72];
            op_ew      = VEC[i][71:70];
            dst_ew     = VEC[i][69:68];
            rev_op     = VEC[i][67];
            le_mode    = VEC[i][66];
            sat_en     = VEC[i][65];
            sat_signed = VEC[i][64];
        end
        @(negedge clk);
        check("R2 valid last", {63'd0, out_valid}, 64'd1);
        check("R6 last data", out_data, VEC[NV-1][63:0]);

        // R3: idle input with different data must not change the output.
        held = out_data;
        in_valid = 1'b0;
        in_data  = 64'h0000_0000_0000_0042;
        @(negedge clk);
        check("R2 idle valid", {63'd0, out_valid}, 64'd0);
        check("R3 hold", out_data, held);
        @(negedge clk);
        check("R3 hold 2", out_data, held);

        // R5: junk above op width does not change a 16-bit swap.
        in_valid = 1'b1; in_data = 64'h5555_5555_5555_1234;
        op_ew = 2'd1; dst_ew = 2'd3; rev_op = 1'b0; le_mode = 1'b0; sat_en = 1'b0;
        @(negedge clk);
        check("R5 swap16 junk", out_data, 64'h0000_0000_0000_3412);

        // R4: rev_op=1, le_mode=0 passes bytes through.
        rev_op = 1'b1; le_mode = 1'b0;
        @(negedge clk);
        check("R4 no swap", out_data, 64'h0000_0000_0000_1234);

        // R1: reset in mid-run clears both outputs.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 midrun valid", {63'd0, out_valid}, 64'd0);
        check("R1 midrun data", out_data, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {63'd0, out_valid}, 64'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule